// File: doc/BRIEF.md
# Multi-Channel PWM Timer Bank

This block holds a parameterised number of identical down-counting channels behind a plain 32-bit register bus. A bus access completes in one cycle. Each channel runs either as a periodic timer or as a pulse-width generator. In pulse-width mode the channel's output pin alternates between a low phase and a high phase, and each phase has its own reload value, so the two durations are set independently. Every channel also raises a maskable interrupt each time its counter reloads.

Each channel has a main register group at a fixed stride. The group holds the low-phase reload, the control word and an interrupt-acknowledge location. The high-phase reload values sit in a separate packed array with a four-byte stride. A read-only version word completes the map. To reprogram a channel, software clears its enable bit, writes both reload values, then sets enable again.

Top module: `pwm_timer_bank`

## Requirements
- R1: After reset every pin and interrupt output is low, and every reload and control register reads zero.
- R2: Channel n's low-phase reload sits at n*0x14 and its control word at n*0x14+0x08. Its high-phase reload sits at 0xB0+n*4. All three read back what was written. Only control bits 3:0 are stored (bit0 enable, bit1 reload mode, bit2 interrupt mask, bit3 pulse-width mode), and the upper bits read zero.
- R3: Address 0xAC returns the VERSION parameter, and writes to it have no effect.
- R4: While a channel's enable bit is clear, its pin is low from the cycle after the clearing write.
- R5: In pulse-width mode, after enable the pin is low for L cycles and then high for H cycles, repeating with period L+H. L is the low-phase reload and H is the high-phase reload, each at least 1.
- R6: With bit3 clear the channel is a plain timer. It reloads with L every L cycles, and its pin stays low.
- R7: Each reload sets the channel's raw interrupt status. The interrupt output equals the raw status gated by the inverse of control bit2. Setting the mask hides a pending status, and clearing the mask shows it again.
- R8: A read of n*0x14+0x0C returns zero and clears channel n's raw status.
- R9: A reload value written while the channel runs does not alter the current phase. It is used from the next reload onward.
- R10: Addresses outside the map read zero, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Access strobe, one cycle per access |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from address |
| pwm_out | output | NCH | Per-channel pulse pin |
| irq | output | NCH | Per-channel masked interrupt |

## Verification
Read data is due in the same cycle as the address, so the bench captures it before that cycle's rising edge. Writes and acknowledge reads act at that edge. If the enabling write lands at edge E, the counter loads at E+1, the first high phase starts at E+L+1, and the raw status rises at E+L+1. The bench counts falling edges from the enabling write and sets each expected pin and interrupt value from L, H and that count. Every bus access inside a measured window advances the count by exactly one cycle.

// File: rtl/pwm_timer_pkg.sv
package pwm_timer_pkg;

    localparam int ADDR_W = 8;
    localparam int DATA_W = 32;

    localparam logic [ADDR_W-1:0] GRP_STRIDE  = 8'h14;
    localparam logic [ADDR_W-1:0] OFS_LOW     = 8'h00;
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 8'h08;
    localparam logic [ADDR_W-1:0] OFS_ACK     = 8'h0C;
    localparam logic [ADDR_W-1:0] VER_ADDR    = 8'hAC;
    localparam logic [ADDR_W-1:0] HIGH_BASE   = 8'hB0;
    localparam logic [ADDR_W-1:0] HIGH_STRIDE = 8'h04;

    // control word, bit0 at the right
    typedef struct packed {
        logic pwm_mode;
        logic irq_mask;
        logic reload_mode;
        logic enable;
    } ctrl_t;

    localparam int CTRL_W = $bits(ctrl_t);

    typedef struct packed {
        logic wr_low;
        logic wr_high;
        logic wr_ctrl;
        logic ack;
    } chan_stb_t;

    function automatic logic [ADDR_W-1:0] grp_base(input int n);
        return ADDR_W'(n * int'(GRP_STRIDE));
    endfunction

    function automatic logic [ADDR_W-1:0] high_addr(input int n);
        return ADDR_W'(int'(HIGH_BASE) + n * int'(HIGH_STRIDE));
    endfunction

endpackage

// File: rtl/pwm_timer_regdec.sv
module pwm_timer_regdec
    import pwm_timer_pkg::*;
#(
    parameter int          NCH     = 4,
    parameter int          CNT_W   = 32,
    parameter logic [31:0] VERSION = 32'h3230_312A
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        bus_sel,
    input  logic                        bus_wr,
    input  logic [ADDR_W-1:0]           bus_addr,
    input  logic [NCH-1:0][CNT_W-1:0]   low_q,
    input  logic [NCH-1:0][CNT_W-1:0]   high_q,
    input  ctrl_t [NCH-1:0]             ctrl_q,
    output chan_stb_t [NCH-1:0]         stb,
    output logic [DATA_W-1:0]           rdata
);

    logic wr_en, rd_en;
    logic [3*NCH-1:0] wr_vec;

    assign wr_en = bus_sel & bus_wr;
    assign rd_en = bus_sel & ~bus_wr;

    always_comb begin
        rdata  = '0;
        stb    = '0;
        wr_vec = '0;
        if (bus_addr == VER_ADDR) rdata = VERSION;
        for (int n = 0; n < NCH; n++) begin
            if (bus_addr == ADDR_W'(grp_base(n) + OFS_LOW)) begin
                rdata          = DATA_W'(low_q[n]);
                stb[n].wr_low  = wr_en;
            end
            if (bus_addr == ADDR_W'(grp_base(n) + OFS_CTRL)) begin
                rdata          = DATA_W'(ctrl_q[n]);
                stb[n].wr_ctrl = wr_en;
            end
            if (bus_addr == ADDR_W'(grp_base(n) + OFS_ACK)) begin
                stb[n].ack     = rd_en;
            end
            if (bus_addr == high_addr(n)) begin
                rdata          = DATA_W'(high_q[n]);
                stb[n].wr_high = wr_en;
            end
            wr_vec[3*n]   = stb[n].wr_low;
            wr_vec[3*n+1] = stb[n].wr_ctrl;
            wr_vec[3*n+2] = stb[n].wr_high;
        end
    end

    AST_ONE_WRITE: assert property (@(posedge clk) disable iff (rst)
        $onehot0(wr_vec)); // R2

    AST_WRITE_NEEDS_SEL: assert property (@(posedge clk) disable iff (rst)
        !(bus_sel && bus_wr) |-> (wr_vec == '0)); // R10

endmodule

// File: rtl/pwm_timer_chan.sv
module pwm_timer_chan
    import pwm_timer_pkg::*;
#(
    parameter int CNT_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  chan_stb_t         stb,
    input  logic [DATA_W-1:0] wdata,
    output logic [CNT_W-1:0]  low_q,
    output logic [CNT_W-1:0]  high_q,
    output ctrl_t             ctrl_q,
    output logic              pwm_out,
    output logic              irq
);

    logic [CNT_W-1:0] cnt;
    logic             running;
    logic             raw;
    logic             reload;

    assign reload = ctrl_q.enable && running && (cnt <= CNT_W'(1));
    assign irq    = raw & ~ctrl_q.irq_mask;

    always_ff @(posedge clk) begin
        if (rst) begin
            low_q   <= '0;
            high_q  <= '0;
            ctrl_q  <= '0;
            cnt     <= '0;
            running <= 1'b0;
            pwm_out <= 1'b0;
            raw     <= 1'b0;
        end else begin
            if (stb.wr_low)  low_q  <= wdata[CNT_W-1:0];
            if (stb.wr_high) high_q <= wdata[CNT_W-1:0];
            if (stb.wr_ctrl) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);

            if (!ctrl_q.enable) begin
                running <= 1'b0;
                cnt     <= '0;
                pwm_out <= 1'b0;
            end else if (!running) begin
                running <= 1'b1;
                cnt     <= low_q;
                pwm_out <= 1'b0;
            end else if (reload) begin
                if (ctrl_q.pwm_mode && !pwm_out) begin
                    cnt     <= high_q;
                    pwm_out <= 1'b1;
                end else begin
                    cnt     <= low_q;
                    pwm_out <= 1'b0;
                end
            end else begin
                cnt <= cnt - CNT_W'(1);
            end

            if (reload)       raw <= 1'b1;
            else if (stb.ack) raw <= 1'b0;
        end
    end

    AST_OFF_LOW: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.enable |=> !pwm_out); // R4

    AST_START_LOW: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.enable && !running) |=> !pwm_out); // R5

    AST_HOLD_PHASE: assert property (@(posedge clk) disable iff (rst)
        (ctrl_q.enable && running && cnt > CNT_W'(1)) |=> $stable(pwm_out)); // R5

    AST_TIMER_LOW: assert property (@(posedge clk) disable iff (rst)
        !ctrl_q.pwm_mode |=> !pwm_out); // R6

    AST_RELOAD_RAISE: assert property (@(posedge clk) disable iff (rst)
        reload |=> raw); // R7

    AST_ACK_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (stb.ack && !reload) |=> !raw); // R8

endmodule

// File: rtl/pwm_timer_bank.sv
module pwm_timer_bank
    import pwm_timer_pkg::*;
#(
    parameter int          NCH     = 4,
    parameter int          CNT_W   = 32,
    parameter logic [31:0] VERSION = 32'h3230_312A
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           bus_sel,
    input  logic           bus_wr,
    input  logic [7:0]     bus_addr,
    input  logic [31:0]    bus_wdata,
    output logic [31:0]    bus_rdata,
    output logic [NCH-1:0] pwm_out,
    output logic [NCH-1:0] irq
);

    logic [NCH-1:0][CNT_W-1:0] low_q;
    logic [NCH-1:0][CNT_W-1:0] high_q;
    ctrl_t [NCH-1:0]           ctrl_q;
    chan_stb_t [NCH-1:0]       stb;

    pwm_timer_regdec #(
        .NCH     (NCH),
        .CNT_W   (CNT_W),
        .VERSION (VERSION)
    ) u_dec (
        .clk      (clk),
        .rst      (rst),
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .low_q    (low_q),
        .high_q   (high_q),
        .ctrl_q   (ctrl_q),
        .stb      (stb),
        .rdata    (bus_rdata)
    );

    for (genvar n = 0; n < NCH; n++) begin : g_chan
        pwm_timer_chan #(
            .CNT_W (CNT_W)
        ) u_chan (
            .clk     (clk),
            .rst     (rst),
            .stb     (stb[n]),
            .wdata   (bus_wdata),
            .low_q   (low_q[n]),
            .high_q  (high_q[n]),
            .ctrl_q  (ctrl_q[n]),
            .pwm_out (pwm_out[n]),
            .irq     (irq[n])
        );
    end

endmodule

// File: tb/tb_pwm_timer_bank.sv
module tb_pwm_timer_bank;

    localparam int          NCH = 4;
    localparam logic [31:0] VER = 32'h3230_312A;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic           bus_sel = 1'b0;
    logic           bus_wr = 1'b0;
    logic [7:0]     bus_addr = '0;
    logic [31:0]    bus_wdata = '0;
    logic [31:0]    bus_rdata;
    logic [NCH-1:0] pwm_out;
    logic [NCH-1:0] irq;

    int  nchk = 0;
    int  nerr = 0;
    int  k = 0;
    bit  done = 0;

    always #4 clk = ~clk;

    pwm_timer_bank #(.NCH(NCH), .CNT_W(32), .VERSION(VER)) dut (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .pwm_out(pwm_out), .irq(irq)
    );

    function automatic logic [7:0] a_low(int n);  return 8'(n * 20);      endfunction
    function automatic logic [7:0] a_ctrl(int n); return 8'(n * 20 + 8);  endfunction
    function automatic logic [7:0] a_ack(int n);  return 8'(n * 20 + 12); endfunction
    function automatic logic [7:0] a_high(int n); return 8'(176 + n * 4); endfunction

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        nchk++;
        if (!ok) begin
            nerr++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk); @(negedge clk); k++;
    endtask

    task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        tick();
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        tick();
        bus_sel = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            nerr++; nchk++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("Result: errors=%0d of %0d checks", nerr, nchk);
            $finish;
        end
    end

    initial begin
        logic [31:0] d;
        int bad;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        check(pwm_out == '0 && irq == '0, "R1", "outputs after reset", {pwm_out, irq}, 0);
        for (int n = 0; n < NCH; n++) begin
            bus_read(a_low(n), d);  check(d == 0, "R1", "low reload reset", d, 0);
            bus_read(a_ctrl(n), d); check(d == 0, "R1", "ctrl reset", d, 0);
            bus_read(a_high(n), d); check(d == 0, "R1", "high reload reset", d, 0);
        end

        // R2 address map sweep
        for (int n = 0; n < NCH; n++) begin
            bus_write(a_low(n),  32'h100 + n);
            bus_write(a_high(n), 32'h200 + n);
            bus_write(a_ctrl(n), 32'hFFFF_FFFE);
        end
        for (int n = 0; n < NCH; n++) begin
            bus_read(a_low(n), d);  check(d == 32'h100 + n, "R2", "low readback", d, 32'h100 + n);
            bus_read(a_high(n), d); check(d == 32'h200 + n, "R2", "high readback", d, 32'h200 + n);
            bus_read(a_ctrl(n), d); check(d == 32'hE, "R2", "ctrl readback", d, 32'hE);
        end

        // R3 version
        bus_read(8'hAC, d); check(d == VER, "R3", "version", d, VER);
        bus_write(8'hAC, 32'h0);
        bus_read(8'hAC, d); check(d == VER, "R3", "version after write", d, VER);

        // R10 unmapped addresses
        bus_write(8'h04, 32'hFFFF_FFFF);
        bus_write(8'h10, 32'hFFFF_FFFF);
        bus_write(8'h60, 32'hFFFF_FFFF);
        bus_write(8'hA8, 32'hFFFF_FFFF);
        bus_write(8'hC0, 32'hFFFF_FFFF);
        bus_read(8'h04, d); check(d == 0, "R10", "read 0x04", d, 0);
        bus_read(8'h10, d); check(d == 0, "R10", "read 0x10", d, 0);
        bus_read(8'h60, d); check(d == 0, "R10", "read 0x60", d, 0);
        bus_read(8'hC0, d); check(d == 0, "R10", "read 0xC0", d, 0);
        for (int n = 0; n < NCH; n++) begin
            bus_read(a_low(n), d);  check(d == 32'h100 + n, "R10", "low untouched", d, 32'h100 + n);
            bus_read(a_high(n), d); check(d == 32'h200 + n, "R10", "high untouched", d, 32'h200 + n);
        end
        check(pwm_out == '0, "R4", "disabled pins low", pwm_out, 0);

        // R5 pulse sweep over L,H in 1..3
        for (int L = 1; L <= 3; L++) begin
            for (int H = 1; H <= 3; H++) begin
                int ch;
                ch = (L * 3 + H) % NCH;
                bus_write(a_ctrl(ch), 32'hE);
                bus_write(a_low(ch), L);
                bus_write(a_high(ch), H);
                tick();
                check(pwm_out == '0, "R4", "pins low before enable", pwm_out, 0);
                bus_write(a_ctrl(ch), 32'hF);
                k = 0;
                bad = 0;
                for (int i = 0; i < 2 * (L + H); i++) begin
                    logic e;
                    tick();
                    e = (((k - 1) % (L + H)) >= L);
                    if (pwm_out[ch] !== e) bad++;
                    if ((pwm_out & ~(NCH'(1) << ch)) != '0) bad++;
                end
                check(bad == 0, "R5", $sformatf("waveform L=%0d H=%0d", L, H), bad, 0);
                bus_write(a_ctrl(ch), 32'hE);
                tick();
                check(pwm_out[ch] == 1'b0, "R4", "pin low after disable", pwm_out[ch], 0);
                repeat (4) begin
                    tick();
                    if (pwm_out[ch]) bad++;
                end
                check(bad == 0, "R4", "pin held low", bad, 0);
            end
        end

        // R6/R7/R8 timer mode on channel 2, L=40
        bus_read(a_ack(2), d);
        check(d == 0, "R8", "ack reads zero", d, 0);
        bus_write(a_low(2), 40);
        bus_write(a_ctrl(2), 32'h3);
        k = 0;
        bad = 0;
        while (k < 40) begin
            tick();
            if (irq[2] || pwm_out[2]) bad++;
        end
        check(bad == 0, "R6", "quiet before first reload", bad, 0);
        tick();
        check(irq[2] == 1'b1, "R7", "irq at first reload", irq[2], 1);
        check(pwm_out[2] == 1'b0, "R6", "timer pin stays low", pwm_out[2], 0);
        bus_read(a_ack(2), d);
        check(irq[2] == 1'b0, "R8", "irq cleared by ack", irq[2], 0);
        bus_write(a_ctrl(2), 32'h7);
        while (k < 81) begin
            tick();
            if (pwm_out[2]) bad++;
        end
        check(irq[2] == 1'b0, "R7", "masked at second reload", irq[2], 0);
        check(bad == 0, "R6", "timer pin low through period", bad, 0);
        bus_write(a_ctrl(2), 32'h3);
        check(irq[2] == 1'b1, "R7", "pending shown after unmask", irq[2], 1);
        bus_write(a_ctrl(2), 32'hE);
        bus_read(a_ack(2), d);

        // R9 reload change mid-phase on channel 1
        bus_write(a_ctrl(1), 32'hE);
        bus_write(a_low(1), 4);
        bus_write(a_high(1), 4);
        bus_write(a_ctrl(1), 32'hF);
        k = 0;
        tick(); tick();
        bus_write(a_low(1), 2);
        bad = 0;
        while (k <= 14) begin
            logic e;
            e = (k >= 5 && k <= 8) || (k >= 11);
            if (pwm_out[1] !== e) bad++;
            tick();
        end
        check(bad == 0, "R9", "new low reload used from next reload", bad, 0);
        bus_write(a_ctrl(1), 32'hE);

        done = 1;
        $display("Result: errors=%0d of %0d checks", nerr, nchk);
        $finish;
    end

endmodule